// File: doc/BRIEF.md
# Outbound Address Window Translator

This block holds a small bank of programmable address windows and uses them to redirect outgoing 64-bit addresses. Each window has a 64-bit start address, an end address, a 64-bit destination base, a transaction type and a function number. When a request falls inside an enabled window, the block returns the destination base plus the request's distance from the window start, together with the window's type and function number. When no enabled window covers the request, the address is returned unchanged and flagged as a miss.

Every window is programmed through one 32-bit write port. A selector register at offset 0 picks the window, and offsets 1 to 7 then write that window's fields. The upper half of a window's end address normally repeats the upper half of its start address. In that mode, a window whose low limit is numerically below its low base holds no addresses at all. Setting the wide-limit flag replaces the low `ULIM_W` bits of the end's upper half with the window's upper-limit register, so a window can cross a 4 GiB boundary. Software should set that flag exactly when the upper 32 bits of (start + size − 1) are greater than the upper 32 bits of the start. The size alone does not decide it.

Lookups are pipelined with one cycle of latency. A small response state machine has three states. `RSP_IDLE` means no result. `RSP_HIT` means a translated result. `RSP_MISS` means the address was passed through. On every clock, a valid request moves the machine to `RSP_HIT` or `RSP_MISS` according to the lookup. A cycle without a request returns it to `RSP_IDLE`, from any of the three states.

Top module: `ob_xlat_matcher`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every window is disabled with all fields zero, so the first lookups miss.
- R2: A request accepted on clock edge N produces `rsp_valid` = 1 after edge N. A cycle with `req_valid` = 0 gives `rsp_valid` = 0 after that edge.
- R3: The start address is {base_hi, base_lo} with its low `GRAN_W` bits forced to 0. The end address has its low `GRAN_W` bits forced to 1. A request hits when start ≤ address ≤ end, compared as unsigned 64-bit values.
- R4: With the wide-limit flag (control bit 16) clear, the end address is {base_hi, lim_lo}. For base 0xF0000000 with lim_lo 0x0FFFFFFF, the window is empty, and addresses from 0x1_0000_0000 upward miss it.
- R5: With the wide-limit flag set, end bits [32+ULIM_W−1:32] come from the upper-limit register (offset 5). The other end bits [63:32+ULIM_W] still come from base_hi.
- R6: On a hit, `rsp_addr` = {tgt_hi, tgt_lo} + (address − start), taken modulo 2^64.
- R7: On a miss, `rsp_hit` = 0, `rsp_addr` equals the request address, and `rsp_region`, `rsp_type` and `rsp_func` are all 0.
- R8: When several windows hit, the lowest-numbered window wins.
- R9: A window with its enable bit (control bit 31) clear never hits.
- R10: On a hit, `rsp_type` reports control bits [4:0] and `rsp_func` reports control bits [12:8] of the winning window.
- R11: Offset 0 stores the window selector from the low `IDX_W` bits of the write data. Offsets 1 to 7 write only the selected window: control, base_lo, base_hi, lim_lo, lim_hi, tgt_lo and tgt_hi, in that offset order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_off | input | 3 | Configuration register offset |
| cfg_wr_data | input | 32 | Configuration write data |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 64 | Address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | Result came from a window |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_region | output | IDX_W | Index of the winning window |
| rsp_type | output | 5 | Transaction type of the winning window |
| rsp_func | output | 5 | Function number of the winning window |

## Verification
The hardest case to reach from the ports is a window whose limit lies below its base within the same upper half. Such a window must be empty, and it is easy to misjudge as a large window. The stimulus first programs exactly that case and probes addresses on both sides of the 4 GiB line. It then sets the wide-limit flag with junk in the unused upper-limit bits, and probes again to show that only `ULIM_W` bits are used. A second window overlapping the first tests priority. A disabled window with a matching range, and a destination base that wraps past 2^64, cover the remaining corners. Beyond these directed cases, boundary sweeps at every window edge and about 1500 pseudo-random addresses are compared against an arithmetic model kept in the bench.

// File: rtl/ob_xlat_pkg.sv
package ob_xlat_pkg;

    // Configuration register offsets seen on the write port.
    typedef enum logic [2:0] {
        OFF_VIEW    = 3'd0,
        OFF_CTRL    = 3'd1,
        OFF_BASE_LO = 3'd2,
        OFF_BASE_HI = 3'd3,
        OFF_LIM_LO  = 3'd4,
        OFF_LIM_HI  = 3'd5,
        OFF_TGT_LO  = 3'd6,
        OFF_TGT_HI  = 3'd7
    } cfg_off_e;

    // Control word layout.
    localparam int unsigned TYPE_W       = 5;
    localparam int unsigned FUNC_W       = 5;
    localparam int unsigned CTL_TYPE_LSB = 0;
    localparam int unsigned CTL_FUNC_LSB = 8;
    localparam int unsigned CTL_WIDE_BIT = 16;
    localparam int unsigned CTL_EN_BIT   = 31;

    // Response state machine.
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/ob_xlat_regbank.sv
module ob_xlat_regbank
    import ob_xlat_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned IDX_W       = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [2:0]                            wr_off,
    input  logic [31:0]                           wr_data,
    output logic [NUM_REGIONS-1:0]                en_o,
    output logic [NUM_REGIONS-1:0]                wide_o,
    output logic [NUM_REGIONS-1:0][TYPE_W-1:0]    typ_o,
    output logic [NUM_REGIONS-1:0][FUNC_W-1:0]    func_o,
    output logic [NUM_REGIONS-1:0][63:0]          base_o,
    output logic [NUM_REGIONS-1:0][63:0]          lim_o,
    output logic [NUM_REGIONS-1:0][63:0]          tgt_o
);

    logic [IDX_W-1:0] view_q;

    // Window selector register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            view_q <= '0;
        end else if (wr_en && (cfg_off_e'(wr_off) == OFF_VIEW)) begin
            view_q <= wr_data[IDX_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
        logic              sel;
        logic              en_q;
        logic              wide_q;
        logic [TYPE_W-1:0] typ_q;
        logic [FUNC_W-1:0] func_q;
        logic [31:0]       base_lo_q;
        logic [31:0]       base_hi_q;
        logic [31:0]       lim_lo_q;
        logic [31:0]       lim_hi_q;
        logic [31:0]       tgt_lo_q;
        logic [31:0]       tgt_hi_q;

        assign sel = wr_en && (view_q == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q      <= 1'b0;
                wide_q    <= 1'b0;
                typ_q     <= '0;
                func_q    <= '0;
                base_lo_q <= '0;
                base_hi_q <= '0;
                lim_lo_q  <= '0;
                lim_hi_q  <= '0;
                tgt_lo_q  <= '0;
                tgt_hi_q  <= '0;
            end else if (sel) begin
                case (cfg_off_e'(wr_off))
                    OFF_CTRL: begin
                        en_q   <= wr_data[CTL_EN_BIT];
                        wide_q <= wr_data[CTL_WIDE_BIT];
                        typ_q  <= wr_data[CTL_TYPE_LSB +: TYPE_W];
                        func_q <= wr_data[CTL_FUNC_LSB +: FUNC_W];
                    end
                    OFF_BASE_LO: base_lo_q <= wr_data;
                    OFF_BASE_HI: base_hi_q <= wr_data;
                    OFF_LIM_LO:  lim_lo_q  <= wr_data;
                    OFF_LIM_HI:  lim_hi_q  <= wr_data;
                    OFF_TGT_LO:  tgt_lo_q  <= wr_data;
                    OFF_TGT_HI:  tgt_hi_q  <= wr_data;
                    default: ;
                endcase
            end
        end

        assign en_o[g]   = en_q;
        assign wide_o[g] = wide_q;
        assign typ_o[g]  = typ_q;
        assign func_o[g] = func_q;
        assign base_o[g] = {base_hi_q, base_lo_q};
        assign lim_o[g]  = {lim_hi_q, lim_lo_q};
        assign tgt_o[g]  = {tgt_hi_q, tgt_lo_q};
    end

endmodule

// File: rtl/ob_xlat_window.sv
module ob_xlat_window #(
    parameter int unsigned GRAN_W = 12,
    parameter int unsigned ULIM_W = 8
) (
    input  logic        en,
    input  logic        wide,
    input  logic [63:0] base,
    input  logic [63:0] lim,
    input  logic [63:0] addr,
    output logic [63:0] start_o,
    output logic        hit_o
);

    localparam logic [63:0] GRAN_MASK = (64'd1 << GRAN_W) - 64'd1;
    localparam logic [31:0] ULIM_MASK = 32'((64'd1 << ULIM_W) - 64'd1);

    logic [31:0] end_hi;
    logic [63:0] end_addr;

    always_comb begin
        // Upper end half: the base's upper half, optionally with its low
        // ULIM_W bits replaced by the upper-limit register.
        if (wide) begin
            end_hi = (base[63:32] & ~ULIM_MASK) | (lim[63:32] & ULIM_MASK);
        end else begin
            end_hi = base[63:32];
        end
        start_o  = base & ~GRAN_MASK;
        end_addr = {end_hi, lim[31:0]} | GRAN_MASK;
        hit_o    = en && (addr >= start_o) && (addr <= end_addr);
    end

endmodule

// File: rtl/ob_xlat_select.sv
module ob_xlat_select
    import ob_xlat_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned IDX_W       = 2
) (
    input  logic [NUM_REGIONS-1:0]                hit_vec,
    input  logic [NUM_REGIONS-1:0][63:0]          starts,
    input  logic [NUM_REGIONS-1:0][63:0]          tgts,
    input  logic [NUM_REGIONS-1:0][TYPE_W-1:0]    typs,
    input  logic [NUM_REGIONS-1:0][FUNC_W-1:0]    funcs,
    input  logic [63:0]                           addr,
    output logic                                  any_hit,
    output logic [IDX_W-1:0]                      idx,
    output logic [63:0]                           xaddr,
    output logic [TYPE_W-1:0]                     typ,
    output logic [FUNC_W-1:0]                     func
);

    logic [63:0] sel_start;
    logic [63:0] sel_tgt;

    always_comb begin
        any_hit   = 1'b0;
        idx       = '0;
        sel_start = '0;
        sel_tgt   = '0;
        typ       = '0;
        func      = '0;
        // Walk downwards so the lowest-numbered hit is the last to assign.
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit   = 1'b1;
                idx       = IDX_W'(i);
                sel_start = starts[i];
                sel_tgt   = tgts[i];
                typ       = typs[i];
                func      = funcs[i];
            end
        end
        xaddr = any_hit ? (sel_tgt + (addr - sel_start)) : addr;
    end

endmodule

// File: rtl/ob_xlat_matcher.sv
module ob_xlat_matcher
    import ob_xlat_pkg::*;
#(
    parameter  int unsigned NUM_REGIONS = 4,
    parameter  int unsigned GRAN_W      = 12,
    parameter  int unsigned ULIM_W      = 8,
    localparam int unsigned IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_wr_off,
    input  logic [31:0]       cfg_wr_data,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [63:0]       rsp_addr,
    output logic [IDX_W-1:0]  rsp_region,
    output logic [4:0]        rsp_type,
    output logic [4:0]        rsp_func
);

    logic [NUM_REGIONS-1:0]              en_vec;
    logic [NUM_REGIONS-1:0]              wide_vec;
    logic [NUM_REGIONS-1:0][TYPE_W-1:0]  typ_arr;
    logic [NUM_REGIONS-1:0][FUNC_W-1:0]  func_arr;
    logic [NUM_REGIONS-1:0][63:0]        base_arr;
    logic [NUM_REGIONS-1:0][63:0]        lim_arr;
    logic [NUM_REGIONS-1:0][63:0]        tgt_arr;
    logic [NUM_REGIONS-1:0][63:0]        start_arr;
    logic [NUM_REGIONS-1:0]              hit_vec;

    logic              any_hit;
    logic [IDX_W-1:0]  sel_idx;
    logic [63:0]       sel_addr;
    logic [TYPE_W-1:0] sel_typ;
    logic [FUNC_W-1:0] sel_func;

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [63:0]       addr_q;
    logic [IDX_W-1:0]  region_q;
    logic [TYPE_W-1:0] typ_q;
    logic [FUNC_W-1:0] func_q;

    ob_xlat_regbank #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_off  (cfg_wr_off),
        .wr_data (cfg_wr_data),
        .en_o    (en_vec),
        .wide_o  (wide_vec),
        .typ_o   (typ_arr),
        .func_o  (func_arr),
        .base_o  (base_arr),
        .lim_o   (lim_arr),
        .tgt_o   (tgt_arr)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        ob_xlat_window #(
            .GRAN_W (GRAN_W),
            .ULIM_W (ULIM_W)
        ) win_i (
            .en      (en_vec[g]),
            .wide    (wide_vec[g]),
            .base    (base_arr[g]),
            .lim     (lim_arr[g]),
            .addr    (req_addr),
            .start_o (start_arr[g]),
            .hit_o   (hit_vec[g])
        );
    end

    ob_xlat_select #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) sel_i (
        .hit_vec (hit_vec),
        .starts  (start_arr),
        .tgts    (tgt_arr),
        .typs    (typ_arr),
        .funcs   (func_arr),
        .addr    (req_addr),
        .any_hit (any_hit),
        .idx     (sel_idx),
        .xaddr   (sel_addr),
        .typ     (sel_typ),
        .func    (sel_func)
    );

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            RSP_IDLE, RSP_HIT, RSP_MISS: begin
                if (req_valid) begin
                    state_d = any_hit ? RSP_HIT : RSP_MISS;
                end else begin
                    state_d = RSP_IDLE;
                end
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result data captured with each accepted request.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            region_q <= '0;
            typ_q    <= '0;
            func_q   <= '0;
        end else if (req_valid) begin
            addr_q   <= sel_addr;
            region_q <= sel_idx;
            typ_q    <= sel_typ;
            func_q   <= sel_func;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rsp_addr   = addr_q;
        rsp_region = region_q;
        rsp_type   = typ_q;
        rsp_func   = func_q;
        unique case (state_q)
            RSP_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
            end
            RSP_MISS: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b0;
            end
            default: begin
                rsp_valid = 1'b0;
                rsp_hit   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ob_xlat_chk.sv
module ob_xlat_chk #(
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned IDX_W       = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic [63:0]            req_addr,
    input logic                   rsp_valid,
    input logic                   rsp_hit,
    input logic [63:0]            rsp_addr,
    input logic [IDX_W-1:0]       rsp_region,
    input logic [4:0]             rsp_type,
    input logic [4:0]             rsp_func,
    input logic [NUM_REGIONS-1:0] hit_vec,
    input logic [NUM_REGIONS-1:0] en_vec
);

    logic [NUM_REGIONS-1:0] below_mask;
    assign below_mask = (NUM_REGIONS'(1) << rsp_region) - NUM_REGIONS'(1);

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rsp_valid);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_without_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_miss_passthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |->
            (rsp_addr == $past(req_addr)) && (rsp_region == '0) &&
            (rsp_type == '0) && (rsp_func == '0));

    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> ((($past(hit_vec) >> rsp_region) & NUM_REGIONS'(1)) != '0) &&
                    (($past(hit_vec) & below_mask) == '0));

    assert_disabled_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~en_vec) == '0);

endmodule

bind ob_xlat_matcher ob_xlat_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_addr   (rsp_addr),
    .rsp_region (rsp_region),
    .rsp_type   (rsp_type),
    .rsp_func   (rsp_func),
    .hit_vec    (hit_vec),
    .en_vec     (en_vec)
);

// File: tb/ob_xlat_matcher_tb_top.sv
module ob_xlat_matcher_tb_top;

    localparam int unsigned NREG    = 4;
    localparam int unsigned GRAN    = 12;
    localparam int unsigned ULIM    = 8;
    localparam int unsigned IDXW    = 2;
    localparam time         CLK_PER = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_off = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [63:0] rsp_addr;
    logic [IDXW-1:0] rsp_region;
    logic [4:0]  rsp_type;
    logic [4:0]  rsp_func;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    logic [31:0] m_ctrl [NREG];
    logic [31:0] m_blo  [NREG];
    logic [31:0] m_bhi  [NREG];
    logic [31:0] m_llo  [NREG];
    logic [31:0] m_lhi  [NREG];
    logic [31:0] m_tlo  [NREG];
    logic [31:0] m_thi  [NREG];

    always #(CLK_PER / 2) clk = ~clk;

    ob_xlat_matcher #(
        .NUM_REGIONS (NREG),
        .GRAN_W      (GRAN),
        .ULIM_W      (ULIM)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_off  (cfg_wr_off),
        .cfg_wr_data (cfg_wr_data),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_addr    (rsp_addr),
        .rsp_region  (rsp_region),
        .rsp_type    (rsp_type),
        .rsp_func    (rsp_func)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%016h expected 0x%016h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] win_start(input int i);
        logic [63:0] s;
        s = {m_bhi[i], m_blo[i]};
        s[GRAN-1:0] = '0;
        return s;
    endfunction

    function automatic logic [63:0] win_end(input int i);
        logic [31:0] eh;
        logic [63:0] e;
        eh = m_ctrl[i][16] ? {m_bhi[i][31:ULIM], m_lhi[i][ULIM-1:0]} : m_bhi[i];
        e  = {eh, m_llo[i]};
        e[GRAN-1:0] = '1;
        return e;
    endfunction

    function automatic void model(input logic [63:0] a, output logic h, output int idx,
                                  output logic [63:0] xa, output logic [4:0] t,
                                  output logic [4:0] f);
        h = 1'b0; idx = 0; xa = a; t = '0; f = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (m_ctrl[i][31] && a >= win_start(i) && a <= win_end(i)) begin
                h   = 1'b1;
                idx = i;
                xa  = {m_thi[i], m_tlo[i]} + (a - win_start(i));
                t   = m_ctrl[i][4:0];
                f   = m_ctrl[i][12:8];
            end
        end
    endfunction

    task automatic wr(input logic [2:0] off, input logic [31:0] data);
        @(negedge clk);
        req_valid   = 1'b0;
        cfg_wr_en   = 1'b1;
        cfg_wr_off  = off;
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    task automatic program_win(input int i, input logic [31:0] ctrl,
                               input logic [63:0] base, input logic [63:0] lim,
                               input logic [63:0] tgt);
        wr(3'd0, 32'(i));
        wr(3'd1, ctrl);
        wr(3'd2, base[31:0]);
        wr(3'd3, base[63:32]);
        wr(3'd4, lim[31:0]);
        wr(3'd5, lim[63:32]);
        wr(3'd6, tgt[31:0]);
        wr(3'd7, tgt[63:32]);
        m_ctrl[i] = ctrl;
        m_blo[i] = base[31:0];  m_bhi[i] = base[63:32];
        m_llo[i] = lim[31:0];   m_lhi[i] = lim[63:32];
        m_tlo[i] = tgt[31:0];   m_thi[i] = tgt[63:32];
    endtask

    task automatic lookup(input logic [63:0] a, input string tag);
        logic        eh;
        int          ei;
        logic [63:0] ea;
        logic [4:0]  et;
        logic [4:0]  ef;
        model(a, eh, ei, ea, et, ef);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        #1;
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(tag, "rsp_hit", 64'(rsp_hit), 64'(eh));
        chk(tag, "rsp_addr", rsp_addr, ea);
        chk(tag, "rsp_region", 64'(rsp_region), 64'(ei));
        chk(tag, "rsp_type", 64'(rsp_type), 64'(et));
        chk(tag, "rsp_func", 64'(rsp_func), 64'(ef));
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(tag, "rsp_valid idle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic sweep_edges(input int i, input string tag);
        logic [63:0] s;
        logic [63:0] e;
        s = win_start(i);
        e = win_end(i);
        lookup(s - 64'd1, tag);
        lookup(s, tag);
        lookup(s + 64'd1, tag);
        lookup(s + ((e - s) >> 1), tag);
        lookup(e - 64'd1, tag);
        lookup(e, tag);
        lookup(e + 64'd1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        for (int i = 0; i < NREG; i++) begin
            m_ctrl[i] = '0; m_blo[i] = '0; m_bhi[i] = '0; m_llo[i] = '0;
            m_lhi[i] = '0; m_tlo[i] = '0; m_thi[i] = '0;
        end

        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        lookup(64'h1234_5678_9ABC_DEF0, "R1/R7");
        lookup(64'h0, "R1/R7");
        idle_check("R2");

        // Window 0: 64 KiB at 0x1_0000_0000, flag clear
        program_win(0, 32'h8000_0204, 64'h0000_0001_0000_0000,
                    64'h0000_0000_0000_FFFF, 64'h0000_0000_8000_0000);
        sweep_edges(0, "R3/R6/R10");
        lookup(64'h0000_0001_0000_0123, "R6");
        chk("R6", "literal translation", rsp_addr, 64'h0000_0000_8000_0123);
        idle_check("R2");

        // Window 1: base 0xF0000000, size 0x20000000, flag clear -> empty
        program_win(1, 32'h8000_0102, 64'h0000_0000_F000_0000,
                    64'h0000_0001_0FFF_FFFF, 64'h0000_00AA_0000_0000);
        lookup(64'h0000_0001_0001_0000, "R4");
        chk("R4", "above 4GiB misses", 64'(rsp_hit), 64'd0);
        lookup(64'h0000_0001_0FFF_FFFF, "R4");
        chk("R4", "wrapped limit misses", 64'(rsp_hit), 64'd0);
        lookup(64'h0000_0000_F000_0000, "R4");
        chk("R4", "base itself misses", 64'(rsp_hit), 64'd0);
        lookup(64'h0000_0000_FFFF_FFFF, "R4");

        // Wide-limit flag with junk above ULIM bits of the upper limit
        program_win(1, 32'h8001_0102, 64'h0000_0000_F000_0000,
                    64'hFFFF_FF01_0FFF_FFFF, 64'h0000_00AA_0000_0000);
        lookup(64'h0000_0000_F000_0000, "R5");
        chk("R5", "base hits with flag", 64'(rsp_hit), 64'd1);
        lookup(64'h0000_0001_0FFF_FFFF, "R5");
        chk("R5", "extended end hits", 64'(rsp_hit), 64'd1);
        lookup(64'h0000_0001_1000_0000, "R5");
        chk("R5", "past extended end misses", 64'(rsp_hit), 64'd0);
        lookup(64'hFFFF_FF01_0000_0000, "R5");
        chk("R5", "unused upper bits ignored", 64'(rsp_hit), 64'd0);
        sweep_edges(1, "R5/R6");

        // R8: overlap of windows 0 and 1
        lookup(64'h0000_0001_0000_0010, "R8");
        chk("R8", "lowest window wins", 64'(rsp_region), 64'd0);

        // Window 2 disabled, window 3 with granularity and type/func
        program_win(2, 32'h0000_0307, 64'h8000_0000_0000_0000,
                    64'h8000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_F000);
        lookup(64'h8000_0000_0000_2000, "R9");
        chk("R9", "disabled window misses", 64'(rsp_hit), 64'd0);
        program_win(3, 32'h8000_1F1F, 64'h0000_0002_5000_0ABC,
                    64'h0000_0000_5000_1001, 64'h0000_0003_0000_0000);
        lookup(64'h0000_0002_5000_0000, "R3");
        chk("R3", "start low bits forced zero", 64'(rsp_hit), 64'd1);
        lookup(64'h0000_0002_5000_1FFF, "R3");
        chk("R3", "end low bits forced one", 64'(rsp_hit), 64'd1);
        chk("R10", "type", 64'(rsp_type), 64'h1F);
        chk("R10", "func", 64'(rsp_func), 64'h1F);
        lookup(64'h0000_0002_5000_2000, "R3");
        chk("R3", "beyond end misses", 64'(rsp_hit), 64'd0);
        sweep_edges(3, "R3/R10");

        // R11: writes to window 3 left the others untouched
        lookup(64'h8000_0000_0000_2000, "R11");
        chk("R11", "window 2 still disabled", 64'(rsp_hit), 64'd0);
        sweep_edges(0, "R11");
        sweep_edges(1, "R11");

        // Enable window 2 through the selector, control word only
        wr(3'd0, 32'd2);
        wr(3'd1, 32'h8000_0307);
        m_ctrl[2] = 32'h8000_0307;
        lookup(64'h8000_0000_0000_2000, "R6/R11");
        chk("R6", "64-bit wrap of target", rsp_addr, 64'h0000_0000_0000_1000);
        chk("R11", "region index", 64'(rsp_region), 64'd2);
        sweep_edges(2, "R6/R9");
        idle_check("R2");

        // Mixed sweep, back-to-back requests
        x = 64'h9E37_79B9_7F4A_7C15;
        for (int k = 0; k < 1500; k++) begin
            logic [63:0] a;
            int w;
            x ^= x << 13;
            x ^= x >> 7;
            x ^= x << 17;
            w = k % NREG;
            case (k % 3)
                0:       a = x;
                1:       a = win_start(w) + (x & 64'h3FFF);
                default: a = win_end(w) - (x & 64'hFF) + 64'h80;
            endcase
            lookup(a, "R2/R3/R6/R8");
        end
        idle_check("R2");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule